// File: doc/BRIEF.md
# Configuration ROM Word-Read Register

This block is a single 32-bit control/status register through which software fetches 16-bit words from a 1024-byte configuration memory image. Software writes the byte address shifted left by one, with the command bit (bit 1) at 0, to start a fetch. It then polls the register until the valid flag (bit 0) reads 1. When the flag is set, the fetched word is in bits 31 to 16.

Behind the register, the block reads the image through a synchronous memory read port. That port has a request/grant handshake, and its response comes back after a latency that can vary. A watchdog counter is sized from the clock frequency and a time limit in microseconds. It abandons a fetch that runs too long and raises a sticky error flag, which software clears by writing 1 to it. Register reads are snapshots taken into a registered read-data port, so polling at any rate leaves the fetch alone.

Top module: `cfgrom_rd_csr`

## Requirements
- R1: After reset a register read returns 0x00000002: command bit 1 = 1, valid bit 0 = 0, error bit 2 = 0, data bits 31:16 = 0.
- R2: A write with bit 1 = 0 while the command bit is 1 starts a fetch. The command bit and the valid flag go to 0, the data field is cleared, and the word address sent to the memory port is write bits 10:2 (byte address / 2).
- R3: The memory request stays high with a stable address until it is granted. It drops in the cycle after the grant, so each fetch makes exactly one granted request.
- R4: In the cycle after the memory port signals returned data, the valid flag becomes 1, the command bit returns to 1, and the returned word appears in bits 31:16.
- R5: A write with bit 1 = 1 starts no fetch: no memory request is made, and the command bit, valid flag and data are unchanged.
- R6: Register reads issued at any time during a fetch do not alter it. The fetch completes with the correct word for its address, and a read returns the register value as it stood in the cycle the read was issued.
- R7: A start write made while a fetch is in flight is ignored. No second request is made, and the word delivered is the one for the first address.
- R8: If no data returns within CLK_MHZ*TMO_US cycles of the start, the fetch is abandoned. The error bit (bit 2) becomes 1, the command bit returns to 1, valid stays 0, and the memory request drops.
- R9: The error bit stays set across later reads and successful fetches. It is cleared only by a write with bit 2 = 1.
- R10: A memory data response that arrives while no fetch is waiting for data leaves the valid flag and the data field unchanged.
- R11: Register bits 15:3 always read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_data | input | 32 | Register write value |
| reg_rd_en | input | 1 | Register read strobe |
| reg_rd_data | output | 32 | Register value captured on the cycle after reg_rd_en |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | AW | Memory word address |
| mem_gnt | input | 1 | Memory grant for the pending request |
| mem_rvalid | input | 1 | Memory returned-data strobe |
| mem_rdata | input | 16 | Memory returned word |

## Verification
Several properties are checked on every cycle by the assertions:
- the command bit always mirrors the fetch engine being idle;
- the request is held with a steady address until it is granted;
- completion sets valid and command together;
- an abort leaves error set and valid clear;
- the error bit never drops without a clearing write;
- the watchdog count stays below its limit.

Other behaviours only the bench scenarios can show:
- the right word arrives in the upper half under varied grant and data latencies;
- a start made while a fetch is busy is really ignored;
- heavy polling leaves the result intact;
- the timeout fires at the right cycle count;
- a stray late response is dropped.

// File: rtl/cfgrom_pkg.sv
package cfgrom_pkg;
  localparam int VLD_BIT  = 0;
  localparam int CMD_BIT  = 1;
  localparam int ERR_BIT  = 2;
  localparam int ADDR_LSB = 2;
  localparam int DATA_LSB = 16;
  localparam int DW       = 16;

  typedef enum logic [1:0] {
    FS_IDLE = 2'd0,
    FS_REQ  = 2'd1,
    FS_WAIT = 2'd2
  } fetch_state_t;
endpackage

// File: rtl/cfgrom_wdog.sv
module cfgrom_wdog #(
  parameter int CLK_MHZ = 250,
  parameter int TMO_US  = 5000
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  input  logic busy_i,
  output logic expire_o
);
  localparam int LIMIT = CLK_MHZ * TMO_US;
  localparam int CW    = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (start_i) begin
      cnt_q <= '0;
    end else if (busy_i && cnt_q != LAST) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign expire_o = busy_i && (cnt_q == LAST);

  AST_WDOG_BOUND: assert property (@(posedge clk) disable iff (rst)
    busy_i |-> (cnt_q <= LAST)); // R8
endmodule

// File: rtl/cfgrom_fetch.sv
module cfgrom_fetch
  import cfgrom_pkg::*;
#(
  parameter int AW = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic [AW-1:0] addr_i,
  input  logic          expire_i,
  input  logic          mem_gnt,
  input  logic          mem_rvalid,
  input  logic [DW-1:0] mem_rdata,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  output logic          busy_o,
  output logic          done_o,
  output logic          abort_o,
  output logic [DW-1:0] data_o
);
  fetch_state_t state_q, state_d;

  assign done_o  = (state_q == FS_WAIT) && mem_rvalid;
  assign abort_o = expire_i && !done_o;
  assign busy_o  = (state_q != FS_IDLE);
  assign mem_req = (state_q == FS_REQ);
  assign mem_addr = addr_i;
  assign data_o  = mem_rdata;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      FS_IDLE: if (start_i) state_d = FS_REQ;
      FS_REQ: begin
        if (abort_o)      state_d = FS_IDLE;
        else if (mem_gnt) state_d = FS_WAIT;
      end
      FS_WAIT: if (done_o || abort_o) state_d = FS_IDLE;
      default: state_d = FS_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= FS_IDLE;
    else     state_q <= state_d;
  end

  AST_START_IDLE: assert property (@(posedge clk) disable iff (rst)
    start_i |-> (state_q == FS_IDLE)); // R7
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_gnt && !expire_i) |=> (mem_req && $stable(mem_addr))); // R3
  AST_ONE_REQ: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_gnt) |=> !mem_req); // R3
endmodule

// File: rtl/cfgrom_csr.sv
module cfgrom_csr
  import cfgrom_pkg::*;
#(
  parameter int AW = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [31:0]   wr_data,
  input  logic          rd_en,
  output logic [31:0]   rd_data,
  input  logic          busy_i,
  input  logic          done_i,
  input  logic          abort_i,
  input  logic [DW-1:0] rdata_i,
  output logic          start_o,
  output logic [AW-1:0] addr_o
);
  logic          cmd_q, vld_q, err_q;
  logic [DW-1:0] data_q;
  logic [AW-1:0] addr_q;
  logic [31:0]   view;

  assign start_o = wr_en && cmd_q && !busy_i && !wr_data[CMD_BIT];
  assign addr_o  = addr_q;

  always_comb begin
    view = '0;
    view[VLD_BIT] = vld_q;
    view[CMD_BIT] = cmd_q;
    view[ERR_BIT] = err_q;
    view[DATA_LSB +: DW] = data_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q  <= 1'b1;
      vld_q  <= 1'b0;
      err_q  <= 1'b0;
      data_q <= '0;
      addr_q <= '0;
    end else begin
      if (start_o) begin
        cmd_q  <= 1'b0;
        vld_q  <= 1'b0;
        data_q <= '0;
        addr_q <= wr_data[ADDR_LSB +: AW];
      end else if (done_i) begin
        cmd_q  <= 1'b1;
        vld_q  <= 1'b1;
        data_q <= rdata_i;
      end else if (abort_i) begin
        cmd_q  <= 1'b1;
      end
      if (abort_i)                        err_q <= 1'b1;
      else if (wr_en && wr_data[ERR_BIT]) err_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= view;
  end

  AST_CMD_IDLE: assert property (@(posedge clk) disable iff (rst)
    cmd_q == !busy_i); // R7
  AST_START_CLR: assert property (@(posedge clk) disable iff (rst)
    start_o |=> (!vld_q && !cmd_q)); // R2
  AST_DONE_VALID: assert property (@(posedge clk) disable iff (rst)
    done_i |=> (vld_q && cmd_q)); // R4
  AST_ABORT_ERR: assert property (@(posedge clk) disable iff (rst)
    abort_i |=> (err_q && !vld_q && cmd_q)); // R8
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    (err_q && !(wr_en && wr_data[ERR_BIT])) |=> err_q); // R9
endmodule

// File: rtl/cfgrom_rd_csr.sv
module cfgrom_rd_csr
  import cfgrom_pkg::*;
#(
  parameter int CLK_MHZ = 250,
  parameter int TMO_US  = 5000,
  parameter int AW      = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_wr_en,
  input  logic [31:0]   reg_wr_data,
  input  logic          reg_rd_en,
  output logic [31:0]   reg_rd_data,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_gnt,
  input  logic          mem_rvalid,
  input  logic [15:0]   mem_rdata
);
  logic          start, busy, done, abort, expire;
  logic [AW-1:0] word_addr;
  logic [DW-1:0] fetched;

  cfgrom_csr #(.AW(AW)) u_csr (
    .clk(clk), .rst(rst),
    .wr_en(reg_wr_en), .wr_data(reg_wr_data),
    .rd_en(reg_rd_en), .rd_data(reg_rd_data),
    .busy_i(busy), .done_i(done), .abort_i(abort), .rdata_i(fetched),
    .start_o(start), .addr_o(word_addr)
  );

  cfgrom_fetch #(.AW(AW)) u_fetch (
    .clk(clk), .rst(rst),
    .start_i(start), .addr_i(word_addr), .expire_i(expire),
    .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .mem_req(mem_req), .mem_addr(mem_addr),
    .busy_o(busy), .done_o(done), .abort_o(abort), .data_o(fetched)
  );

  cfgrom_wdog #(.CLK_MHZ(CLK_MHZ), .TMO_US(TMO_US)) u_wdog (
    .clk(clk), .rst(rst),
    .start_i(start), .busy_i(busy), .expire_o(expire)
  );
endmodule

// File: tb/cfgrom_rd_csr_tb.sv
module cfgrom_rd_csr_tb;
  localparam int CLK_MHZ = 1;
  localparam int TMO_US  = 200;
  localparam int LIMIT   = CLK_MHZ * TMO_US;
  localparam int AW      = 9;
  localparam int NEVER   = 65535;

  logic clk = 0, rst = 1;
  logic reg_wr_en = 0, reg_rd_en = 0;
  logic [31:0] reg_wr_data = '0, reg_rd_data;
  logic mem_req, mem_gnt = 0, mem_rvalid = 0;
  logic [AW-1:0] mem_addr;
  logic [15:0] mem_rdata = '0;

  int checks = 0, errors = 0;
  bit finished = 0;

  int gnt_dly = 0, lat = 1, gcnt = 0, lcnt = 0, grants = 0;
  bit pending = 0, inject = 0;
  logic [AW-1:0] last_addr = '0;

  always #2 clk = ~clk;

  cfgrom_rd_csr #(.CLK_MHZ(CLK_MHZ), .TMO_US(TMO_US), .AW(AW)) u_dut (
    .clk(clk), .rst(rst),
    .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data),
    .reg_rd_en(reg_rd_en), .reg_rd_data(reg_rd_data),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_gnt(mem_gnt),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
  );

  function automatic logic [15:0] img(input logic [AW-1:0] a);
    return 16'(a * 16'h9E37) ^ 16'h5A5A;
  endfunction

  // memory model, updated at the falling edge
  always @(negedge clk) begin
    mem_gnt    <= 0;
    mem_rvalid <= 0;
    if (inject) begin
      mem_rvalid <= 1;
      mem_rdata  <= 16'hBEEF;
      inject     <= 0;
    end else if (pending) begin
      lcnt <= lcnt + 1;
      if (lcnt + 1 == lat) begin
        mem_rvalid <= 1;
        mem_rdata  <= img(last_addr);
        pending    <= 0;
      end
    end else if (mem_req === 1'b1) begin
      if (gcnt == gnt_dly) begin
        mem_gnt   <= 1;
        pending   <= 1;
        lcnt      <= 0;
        gcnt      <= 0;
        last_addr <= mem_addr;
        grants    <= grants + 1;
      end else gcnt <= gcnt + 1;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1; reg_wr_data = d;
    @(negedge clk);
    reg_wr_en = 0; reg_wr_data = '0;
  endtask

  task automatic rd(output logic [31:0] v);
    reg_rd_en = 1;
    @(posedge clk);
    @(negedge clk);
    reg_rd_en = 0;
    v = reg_rd_data;
  endtask

  task automatic poll(output logic [31:0] v, output int n);
    n = 0;
    do begin rd(v); n++; end while (!v[1] && n < 2 * LIMIT);
  endtask

  task automatic fetch(input int byte_a, input int gd, input int l, input string tag);
    logic [31:0] v; int n; int g0;
    logic [AW-1:0] w;
    w = AW'(byte_a >> 1);
    gnt_dly = gd; lat = l; g0 = grants;
    wr(32'(byte_a) << 1);
    poll(v, n);
    check(v[0] == 1 && v[31:16] == img(w) && v[15:3] == 0, tag, v, {img(w), 16'h0003});
    check(grants == g0 + 1 && last_addr == w, {tag, " R3 grant/addr"}, 32'(last_addr), 32'(w));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v; int n; int g0;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);

    rd(v); // R1
    check(v == 32'h2, "R1 reset value", v, 32'h2);

    fetch(0, 0, 1, "R4 addr 0");
    fetch(1022, 2, 5, "R4 addr 1022");
    fetch(6, 0, 1, "R2 addr 6");

    // R2: valid and data clear during fetch
    gnt_dly = 1; lat = 20;
    wr(32'd40 << 1);
    rd(v);
    check(v[1:0] == 0 && v[31:16] == 0, "R2 busy view", v, 32'h0);
    poll(v, n);
    check(v[31:16] == img(9'd20), "R6 polled result", v, {img(9'd20), 16'h3});

    // random fetches with constant polling
    for (int i = 0; i < 20; i++) begin
      int a = int'($urandom_range(0, 511)) * 2;
      fetch(a, int'($urandom_range(0, 3)), int'($urandom_range(1, 20)), "R6 random");
    end

    // R5: write with command bit set starts nothing
    g0 = grants;
    wr(32'h0000_0102);
    repeat (6) @(negedge clk);
    rd(v);
    check(grants == g0 && v[1:0] == 2'b11 && v[31:16] != 0, "R5 no start", v, 32'h3);

    // R7: start while busy ignored
    gnt_dly = 0; lat = 30; g0 = grants;
    wr(32'd100 << 1);
    repeat (3) @(negedge clk);
    wr(32'd300 << 1);
    poll(v, n);
    check(grants == g0 + 1, "R7 single grant", 32'(grants - g0), 32'd1);
    check(v[31:16] == img(9'd50), "R7 first word", v, {img(9'd50), 16'h3});

    // R8: timeout
    gnt_dly = 0; lat = NEVER;
    wr(32'd8 << 1);
    poll(v, n);
    check(v[2:0] == 3'b110 && v[31:16] == 0, "R8 abort state", v, 32'h6);
    check(n >= LIMIT && n <= LIMIT + 2, "R8 timeout cycles", 32'(n), 32'(LIMIT + 1));
    check(mem_req == 0, "R8 request dropped", 32'(mem_req), 32'h0);

    // R10: stale response ignored
    pending = 0;
    @(negedge clk); inject = 1;
    repeat (3) @(negedge clk);
    rd(v);
    check(v[0] == 0 && v[31:16] == 0, "R10 stale ignored", v, 32'h6);

    // R9: sticky across a successful fetch, then cleared
    fetch(16, 0, 3, "R9 fetch with error set");
    rd(v);
    check(v[2] == 1, "R9 error sticky", v, 32'h7);
    wr(32'h0000_0006);
    rd(v);
    check(v[2] == 0 && v[1:0] == 2'b11, "R9 error cleared", v, {v[31:16], 16'h3});
    check(v[15:3] == 0, "R11 zero bits", v, {v[31:16], 16'h3});

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule